// File: doc/BRIEF.md
# Delay-Slot Program Counter Sequencer

This block holds the program counter of a 64-bit core whose branches have one delay slot. Each time the step strobe is high, the block takes the control requests of the instruction that is now executing and selects the next PC. That request can be a taken branch with its target, a skip for a likely branch whose condition failed, or an exception with its vector offset. The block also reads the current exception-level and boot-vector status bits. It keeps the saved branch target and a flag that marks the current instruction as sitting in a delay slot.

On an exception the block records the restart address and a branch-delay flag, as long as the core is not already at exception level. It then moves the PC to the exception vector. One step later it raises a request that sets the exception level. Between steps every register holds its value. A synchronous active-high reset starts the block at the boot address.

Top module: `dslot_pc_seq`

## Requirements
- R1: While `rst` is high at a clock edge, `pc` becomes 0xFFFFFFFFBFC00000 and `in_slot`, `epc`, `bd` and `exl_raise` all become 0.
- R2: A step with no exception, no skip and `in_slot` low advances `pc` by 4.
- R3: A step with `br_req` high while `in_slot` is low stores `br_target` and sets `in_slot`. The next step with no exception loads `pc` with the stored target and clears `in_slot`.
- R4: A step with `skip_req` high, no exception and `in_slot` low advances `pc` by 8 and leaves `in_slot` low.
- R5: A step with `exc_req` high while `status_exl` is 1 leaves `epc` and `bd` unchanged.
- R6: A step with `exc_req` high, `status_exl` 0 and `in_slot` 1 loads `epc` with `pc` minus 4 and sets `bd` to 1.
- R7: A step with `exc_req` high, `status_exl` 0 and `in_slot` 0 loads `epc` with `pc` and clears `bd` to 0.
- R8: On an exception step, `pc` becomes a vector base plus `exc_off` sign-extended to 64 bits. The base is 0xFFFFFFFFBFC00200 when `status_bev` is 1 and 0xFFFFFFFF80000000 when it is 0.
- R9: An exception overrides a pending delay-slot redirect and clears `in_slot`. After an exception step, `exl_raise` is 1. After a step with no exception, it is 0.
- R10: When `in_slot` is 1, the redirect to the stored target takes priority over `skip_req`, and `br_req` on that step is ignored, so `in_slot` ends the step at 0.
- R11: While `step` is low, `pc`, `epc`, `bd`, `in_slot` and `exl_raise` keep their values, whatever the request inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | One instruction completes this cycle |
| br_req | input | 1 | Current instruction is a taken branch |
| br_target | input | 64 | Target address of the taken branch |
| skip_req | input | 1 | Likely branch not taken: skip its slot |
| exc_req | input | 1 | Current instruction raises an exception |
| exc_off | input | 16 | Vector offset, sign-extended |
| status_exl | input | 1 | Exception level already set |
| status_bev | input | 1 | Boot exception vectors selected |
| pc | output | 64 | Program counter |
| epc | output | 64 | Exception restart address |
| bd | output | 1 | Faulting instruction was in a delay slot |
| in_slot | output | 1 | Current instruction sits in a delay slot |
| exl_raise | output | 1 | Request to set the exception level |

## Verification
The bench makes a branch and then lets the slot instruction execute. A design that redirected on the branch itself, or that never used the saved target, would show the wrong `pc` on one of those two steps. A skip request arrives while the core is in a delay slot. A design with the wrong priority would jump 8 bytes instead of reaching the target. The bench raises exceptions in a slot and out of one, with the exception level set and clear. A design that confused these cases would write the wrong `epc` or `bd`, or overwrite them when it should not. A negative vector offset with the boot base catches an offset that is zero-extended or a base that is swapped. The bench also drives requests with `step` low and asserts reset in the middle of a branch, to catch state that moves when it should hold.

// File: rtl/dslot_seq_pkg.sv
package dslot_seq_pkg;

    localparam int PC_W = 64;

    typedef enum logic [1:0] {
        SEL_SEQ  = 2'd0,
        SEL_SKIP = 2'd1,
        SEL_SLOT = 2'd2,
        SEL_EXC  = 2'd3
    } next_sel_t;

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic [PC_W-1:0] epc;
        logic [PC_W-1:0] tgt;
        logic            bd;
        logic            slot;
        logic            exl_raise;
    } seq_state_t;

endpackage

// File: rtl/seq_prio.sv
module seq_prio
    import dslot_seq_pkg::*;
(
    input  logic      exc,
    input  logic      slot,
    input  logic      skip,
    output next_sel_t sel
);
    // exception > slot redirect > likely skip > sequential
    always_comb begin
        if (exc)       sel = SEL_EXC;
        else if (slot) sel = SEL_SLOT;
        else if (skip) sel = SEL_SKIP;
        else           sel = SEL_SEQ;
    end
endmodule

// File: rtl/seq_vector.sv
module seq_vector #(
    parameter int          PC_W      = 64,
    parameter int          OFF_W     = 16,
    parameter logic [63:0] BEV_BASE  = 64'hFFFF_FFFF_BFC0_0200,
    parameter logic [63:0] NORM_BASE = 64'hFFFF_FFFF_8000_0000
) (
    input  logic             bev,
    input  logic [OFF_W-1:0] off,
    output logic [PC_W-1:0]  vec
);
    localparam int EXT_W = PC_W - OFF_W;

    logic [PC_W-1:0] base;
    logic [PC_W-1:0] off_x;

    always_comb begin
        base  = bev ? BEV_BASE[PC_W-1:0] : NORM_BASE[PC_W-1:0];
        off_x = {{EXT_W{off[OFF_W-1]}}, off};
        vec   = base + off_x;
    end
endmodule

// File: rtl/seq_epc.sv
module seq_epc #(
    parameter int PC_W       = 64,
    parameter int INSN_BYTES = 4
) (
    input  logic            exl,
    input  logic            slot,
    input  logic [PC_W-1:0] pc,
    input  logic [PC_W-1:0] epc_q,
    input  logic            bd_q,
    output logic [PC_W-1:0] epc_d,
    output logic            bd_d
);
    localparam logic [PC_W-1:0] STRIDE = PC_W'(INSN_BYTES);

    always_comb begin
        if (exl) begin
            epc_d = epc_q;
            bd_d  = bd_q;
        end else if (slot) begin
            epc_d = pc - STRIDE;
            bd_d  = 1'b1;
        end else begin
            epc_d = pc;
            bd_d  = 1'b0;
        end
    end
endmodule

// File: rtl/dslot_pc_seq.sv
module dslot_pc_seq
    import dslot_seq_pkg::*;
#(
    parameter int          OFF_W      = 16,
    parameter int          INSN_BYTES = 4,
    parameter logic [63:0] RESET_PC   = 64'hFFFF_FFFF_BFC0_0000,
    parameter logic [63:0] BEV_BASE   = 64'hFFFF_FFFF_BFC0_0200,
    parameter logic [63:0] NORM_BASE  = 64'hFFFF_FFFF_8000_0000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             br_req,
    input  logic [63:0]      br_target,
    input  logic             skip_req,
    input  logic             exc_req,
    input  logic [OFF_W-1:0] exc_off,
    input  logic             status_exl,
    input  logic             status_bev,
    output logic [63:0]      pc,
    output logic [63:0]      epc,
    output logic             bd,
    output logic             in_slot,
    output logic             exl_raise
);
    localparam logic [PC_W-1:0] STEP1 = PC_W'(INSN_BYTES);
    localparam logic [PC_W-1:0] STEP2 = PC_W'(2 * INSN_BYTES);

    seq_state_t      st_q, st_d;
    next_sel_t       sel;
    logic [PC_W-1:0] vec_pc;
    logic [PC_W-1:0] exc_epc;
    logic            exc_bd;

    seq_prio u_prio (
        .exc  (exc_req),
        .slot (st_q.slot),
        .skip (skip_req),
        .sel  (sel)
    );

    seq_vector #(
        .PC_W      (PC_W),
        .OFF_W     (OFF_W),
        .BEV_BASE  (BEV_BASE),
        .NORM_BASE (NORM_BASE)
    ) u_vec (
        .bev (status_bev),
        .off (exc_off),
        .vec (vec_pc)
    );

    seq_epc #(
        .PC_W       (PC_W),
        .INSN_BYTES (INSN_BYTES)
    ) u_epc (
        .exl   (status_exl),
        .slot  (st_q.slot),
        .pc    (st_q.pc),
        .epc_q (st_q.epc),
        .bd_q  (st_q.bd),
        .epc_d (exc_epc),
        .bd_d  (exc_bd)
    );

    always_comb begin
        st_d = st_q;
        if (step) begin
            st_d.exl_raise = 1'b0;
            st_d.slot      = 1'b0;
            unique case (sel)
                SEL_EXC: begin
                    st_d.pc        = vec_pc;
                    st_d.epc       = exc_epc;
                    st_d.bd        = exc_bd;
                    st_d.exl_raise = 1'b1;
                end
                SEL_SLOT: begin
                    st_d.pc = st_q.tgt;
                end
                SEL_SKIP: begin
                    st_d.pc = st_q.pc + STEP2;
                end
                default: begin
                    st_d.pc   = st_q.pc + STEP1;
                    st_d.slot = br_req;
                    if (br_req) st_d.tgt = br_target;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.pc        <= RESET_PC[PC_W-1:0];
            st_q.epc       <= '0;
            st_q.tgt       <= '0;
            st_q.bd        <= 1'b0;
            st_q.slot      <= 1'b0;
            st_q.exl_raise <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc        = st_q.pc;
    assign epc       = st_q.epc;
    assign bd        = st_q.bd;
    assign in_slot   = st_q.slot;
    assign exl_raise = st_q.exl_raise;
endmodule

// File: rtl/dslot_pc_seq_chk.sv
module dslot_pc_seq_chk #(
    parameter int OFF_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             step,
    input logic             br_req,
    input logic             skip_req,
    input logic             exc_req,
    input logic [OFF_W-1:0] exc_off,
    input logic             status_exl,
    input logic [63:0]      pc,
    input logic [63:0]      epc,
    input logic             bd,
    input logic             in_slot,
    input logic             exl_raise
);
    AST_RESET_PC: assert property (@(posedge clk) rst |=> pc == 64'hFFFF_FFFF_BFC0_0000 && !in_slot); // R1
    AST_SEQ_ADV: assert property (@(posedge clk) disable iff (rst)
        step && !exc_req && !in_slot && !skip_req |=> pc == $past(pc) + 64'd4); // R2
    AST_BR_MARK: assert property (@(posedge clk) disable iff (rst)
        step && br_req && !exc_req && !in_slot && !skip_req |=> in_slot); // R3
    AST_SKIP_ADV: assert property (@(posedge clk) disable iff (rst)
        step && skip_req && !exc_req && !in_slot |=> pc == $past(pc) + 64'd8 && !in_slot); // R4
    AST_EXL_KEEP: assert property (@(posedge clk) disable iff (rst)
        step && exc_req && status_exl |=> $stable(epc) && $stable(bd)); // R5
    AST_SLOT_EPC: assert property (@(posedge clk) disable iff (rst)
        step && exc_req && !status_exl && in_slot |=> epc == $past(pc) - 64'd4 && bd); // R6
    AST_PLAIN_EPC: assert property (@(posedge clk) disable iff (rst)
        step && exc_req && !status_exl && !in_slot |=> epc == $past(pc) && !bd); // R7
    AST_EXC_CLR: assert property (@(posedge clk) disable iff (rst)
        step && exc_req |=> !in_slot && exl_raise); // R9
    AST_SLOT_END: assert property (@(posedge clk) disable iff (rst)
        step && in_slot |=> !in_slot); // R10
    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(pc) && $stable(epc) && $stable(in_slot) && $stable(exl_raise)); // R11

    logic unused_ok;
    assign unused_ok = ^exc_off;
endmodule

bind dslot_pc_seq dslot_pc_seq_chk #(.OFF_W(OFF_W)) u_chk (.*);

// File: tb/sim_dslot_pc_seq.sv
module sim_dslot_pc_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step = 1'b0;
    logic        br_req = 1'b0;
    logic [63:0] br_target = '0;
    logic        skip_req = 1'b0;
    logic        exc_req = 1'b0;
    logic [15:0] exc_off = '0;
    logic        status_exl = 1'b0;
    logic        status_bev = 1'b0;
    logic [63:0] pc, epc;
    logic        bd, in_slot, exl_raise;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dslot_pc_seq u0 (.*);

    typedef struct packed {
        logic        br, skip, exc, exl, bev;
        logic [15:0] off;
        logic [63:0] tgt;
        logic [63:0] pc_e;
        logic        slot_e;
        logic [63:0] epc_e;
        logic        bd_e, raise_e;
        logic [3:0]  req;
    } row_t;

    localparam int NROW = 13;
    localparam row_t TBL [NROW] = '{
        '{1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000,64'h0,   64'hFFFFFFFFBFC00004,1'b0,64'h0,1'b0,1'b0,4'd2},  // R2
        '{1'b1,1'b0,1'b0,1'b0,1'b0,16'h0000,64'h1000,64'hFFFFFFFFBFC00008,1'b1,64'h0,1'b0,1'b0,4'd3},  // R3 mark
        '{1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000,64'h0,   64'h1000,1'b0,64'h0,1'b0,1'b0,4'd3},              // R3 redirect
        '{1'b0,1'b1,1'b0,1'b0,1'b0,16'h0000,64'h0,   64'h1008,1'b0,64'h0,1'b0,1'b0,4'd4},              // R4
        '{1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000,64'h0,   64'h100C,1'b0,64'h0,1'b0,1'b0,4'd2},              // R2
        '{1'b1,1'b0,1'b0,1'b0,1'b0,16'h0000,64'h2000,64'h1010,1'b1,64'h0,1'b0,1'b0,4'd3},              // R3
        '{1'b1,1'b1,1'b0,1'b0,1'b0,16'h0000,64'h9000,64'h2000,1'b0,64'h0,1'b0,1'b0,4'd10},             // R10
        '{1'b1,1'b0,1'b0,1'b0,1'b0,16'h0000,64'h3000,64'h2004,1'b1,64'h0,1'b0,1'b0,4'd3},              // R3
        '{1'b0,1'b0,1'b1,1'b0,1'b0,16'h0180,64'h0,   64'hFFFFFFFF80000180,1'b0,64'h2000,1'b1,1'b1,4'd6}, // R6
        '{1'b1,1'b0,1'b0,1'b0,1'b0,16'h0000,64'h4000,64'hFFFFFFFF80000184,1'b1,64'h2000,1'b1,1'b0,4'd9}, // R9 raise drops
        '{1'b0,1'b0,1'b1,1'b1,1'b1,16'h0000,64'h0,   64'hFFFFFFFFBFC00200,1'b0,64'h2000,1'b1,1'b1,4'd5}, // R5, overrides slot
        '{1'b0,1'b0,1'b1,1'b0,1'b1,16'hFFFC,64'h0,   64'hFFFFFFFFBFC001FC,1'b0,64'hFFFFFFFFBFC00200,1'b0,1'b1,4'd7}, // R7, R8
        '{1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000,64'h0,   64'hFFFFFFFFBFC00200,1'b0,64'hFFFFFFFFBFC00200,1'b0,1'b0,4'd2}  // R2
    };

    function automatic string rname(input logic [3:0] n);
        case (n)
            4'd1:  return "R1";
            4'd2:  return "R2";
            4'd3:  return "R3";
            4'd4:  return "R4";
            4'd5:  return "R5";
            4'd6:  return "R6";
            4'd7:  return "R7";
            4'd8:  return "R8";
            4'd9:  return "R9";
            4'd10: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_step(input row_t r);
        @(negedge clk);
        br_req = r.br; skip_req = r.skip; exc_req = r.exc;
        status_exl = r.exl; status_bev = r.bev; exc_off = r.off; br_target = r.tgt;
        step = 1'b1;
        @(negedge clk);
        step = 1'b0; br_req = 1'b0; skip_req = 1'b0; exc_req = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "pc", pc, 64'hFFFFFFFFBFC00000);
        chk("R1", "in_slot", {63'd0, in_slot}, 64'd0);
        chk("R1", "epc", epc, 64'd0);
        chk("R1", "bd/exl_raise", {62'd0, bd, exl_raise}, 64'd0);
        rst = 1'b0;

        for (int i = 0; i < NROW; i++) begin
            do_step(TBL[i]);
            chk(rname(TBL[i].req), "pc", pc, TBL[i].pc_e);
            chk(rname(TBL[i].req), "in_slot", {63'd0, in_slot}, {63'd0, TBL[i].slot_e});
            chk(rname(TBL[i].req), "epc", epc, TBL[i].epc_e);
            chk(rname(TBL[i].req), "bd", {63'd0, bd}, {63'd0, TBL[i].bd_e});
            chk(rname(TBL[i].req), "exl_raise", {63'd0, exl_raise}, {63'd0, TBL[i].raise_e});
        end

        // R11: requests without step change nothing
        @(negedge clk);
        br_req = 1'b1; br_target = 64'h5000; exc_req = 1'b1; skip_req = 1'b1;
        repeat (3) @(negedge clk);
        br_req = 1'b0; exc_req = 1'b0; skip_req = 1'b0;
        @(negedge clk);
        chk("R11", "pc held", pc, 64'hFFFFFFFFBFC00200);
        chk("R11", "epc held", epc, 64'hFFFFFFFFBFC00200);
        chk("R11", "slot/raise held", {62'd0, in_slot, exl_raise}, 64'd0);

        // R1: reset in the middle of a branch clears the pending slot
        do_step('{1'b1,1'b0,1'b0,1'b0,1'b0,16'h0,64'h7000,64'h0,1'b0,64'h0,1'b0,1'b0,4'd3});
        chk("R3", "slot set before reset", {63'd0, in_slot}, 64'd1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1", "pc after mid reset", pc, 64'hFFFFFFFFBFC00000);
        chk("R1", "slot after mid reset", {63'd0, in_slot}, 64'd0);
        // after reset, no redirect to stale target
        do_step('{1'b0,1'b0,1'b0,1'b0,1'b0,16'h0,64'h0,64'h0,1'b0,64'h0,1'b0,1'b0,4'd2});
        chk("R1", "no stale redirect", pc, 64'hFFFFFFFFBFC00004);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule